// File: doc/BRIEF.md
# Triggerable Output Compare Pulse Generator

This block drives one output from a private 16-bit timer and two compare values. The first compare value marks the rising edge and the second marks the falling edge. Both are counted from a timer value of zero. The timer advances on the cycles when a selected clock-enable input is high. After the period value it returns to zero. Three compare modes are available: toggle on every match of the first value, one single pulse, and a repeating pulse train.

The timer start is set in one of two ways. In synchronous mode the timer runs freely, and an event from a selected source clears it to zero. In trigger mode the timer is held until a trigger arrives. A trigger is either an event from the selected source or a software request. A status bit records the trigger. That bit either clears by itself when the timer rolls over or stays set until software clears it. The output can be inverted. A fault input overrides the output with a programmed safe level, or releases the output drive. Each compare match gives a one-cycle interrupt pulse.

Top module: `oc_pulse_gen`

## Requirements
- R1: After reset, oc_o=0, oc_oe_o=1, irq_o=0, timer_o=0, mode_o=000, trig_stat_o=0 and fault_o=0.
- R2: While mode_o is not 000 and the timer is running, timer_o advances by one on each edge where the tick input chosen by tick_sel_i is high. It holds on the other edges. One edge after it equals period_i, it becomes 0. One edge after mode_o becomes 000, the timer becomes 0 and the compare output is low.
- R3: In mode 011, the output rises on the edge where timer_o becomes cmp_a_i. It falls on the edge where timer_o becomes cmp_b_i. This repeats every period_i+1 ticks.
- R4: In mode 001, the output changes level on each edge where timer_o becomes cmp_a_i.
- R5: In mode 010, the output rises at cmp_a_i and falls at cmp_b_i. On the same edge as the fall, mode_o returns to 000, and the output stays low after that.
- R6: On the edge where timer_o becomes a compare value used by the mode, irq_o is high for exactly one cycle. Mode 001 uses cmp_a_i only. Modes 010 and 011 use cmp_a_i and cmp_b_i.
- R7: A pulse on mode_wr_i loads mode_i into mode_o on the next edge. The encodings are 000 off, 001 toggle, 010 single pulse and 011 repeating. A write with mode_i[2]=1 is ignored.
- R8: With trig_en_i=0 and evt_sel_i=k (1..NSRC), a high evt_i[k-1] clears the timer to 0 on the next edge. With evt_sel_i=0 there is no source, and events have no effect.
- R9: With trig_en_i=1 and trig_stat_o=0, the timer holds its value. A pulse on sw_trig_set_i sets trig_stat_o on the next edge. The timer advances from the edge after that.
- R10: With trig_en_i=1, a high evt_i[k-1] with evt_sel_i=k sets trig_stat_o on the next edge.
- R11: When trig_auto_clr_i=1, trig_stat_o clears on the edge where the timer wraps from period_i to 0. When trig_auto_clr_i=0, it stays set until a sw_trig_clr_i pulse clears it on the next edge, and the timer then holds.
- R12: While no fault is latched, invert_i=1 inverts oc_o in the same cycle.
- R13: While fault_o=1, oc_o equals fault_level_i, with no inversion. If fault_tri_en_i=1, oc_oe_o=0; otherwise oc_oe_o=1.
- R14: fault_i=1 sets fault_o on the next edge. fault_o clears only on the edge after a fault_clr_i pulse that arrives while fault_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | NTICK | Candidate clock-enable inputs for the timer |
| tick_sel_i | input | TSW | Index of the tick input that is used |
| evt_i | input | NSRC | Sync/trigger event inputs |
| evt_sel_i | input | SRCW | Event source: 0 means none, k selects evt_i[k-1] |
| trig_en_i | input | 1 | 1 selects trigger mode, 0 selects synchronous mode |
| trig_auto_clr_i | input | 1 | 1 clears the trigger status on timer rollover |
| sw_trig_set_i | input | 1 | Software trigger pulse |
| sw_trig_clr_i | input | 1 | Software pulse that clears the trigger status |
| mode_wr_i | input | 1 | Pulse that loads mode_i |
| mode_i | input | 3 | New compare mode |
| cmp_a_i | input | TW | Rising-edge / toggle compare value |
| cmp_b_i | input | TW | Falling-edge compare value |
| period_i | input | TW | Last timer value before wrap |
| invert_i | input | 1 | Output polarity inversion |
| fault_i | input | 1 | Fault input, active high |
| fault_level_i | input | 1 | Output level while a fault is latched |
| fault_tri_en_i | input | 1 | Release the output drive during a fault |
| fault_clr_i | input | 1 | Pulse that clears the fault flag |
| oc_o | output | 1 | Compare output |
| oc_oe_o | output | 1 | Output drive enable |
| irq_o | output | 1 | One-cycle match interrupt |
| timer_o | output | TW | Timer value |
| mode_o | output | 3 | Active compare mode |
| trig_stat_o | output | 1 | Trigger status |
| fault_o | output | 1 | Latched fault flag |

## Verification
Timer, mode, trigger status and fault flag change one edge after the input that causes them. A mode write therefore shows on mode_o one cycle later, and the timer takes its first step one cycle after that. The output level and the interrupt change on the same edge where timer_o reaches the compare value. The inversion, fault level and drive enable follow their inputs within the same cycle. Each stimulus task records the result it expects together with the exact cycle number counted from the write. A monitor compares those records only in that cycle, half a period after the edge, so an early or a late result counts as a failure.

// File: rtl/oc_pulse_gen.sv
module oc_pulse_gen #(
  parameter int TW    = 16,
  parameter int NTICK = 4,
  parameter int NSRC  = 4,
  parameter int SRCW  = 5,
  localparam int TSW  = (NTICK > 1) ? $clog2(NTICK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTICK-1:0] tick_i,
  input  logic [TSW-1:0]  tick_sel_i,
  input  logic [NSRC-1:0] evt_i,
  input  logic [SRCW-1:0] evt_sel_i,
  input  logic            trig_en_i,
  input  logic            trig_auto_clr_i,
  input  logic            sw_trig_set_i,
  input  logic            sw_trig_clr_i,
  input  logic            mode_wr_i,
  input  logic [2:0]      mode_i,
  input  logic [TW-1:0]   cmp_a_i,
  input  logic [TW-1:0]   cmp_b_i,
  input  logic [TW-1:0]   period_i,
  input  logic            invert_i,
  input  logic            fault_i,
  input  logic            fault_level_i,
  input  logic            fault_tri_en_i,
  input  logic            fault_clr_i,
  output logic            oc_o,
  output logic            oc_oe_o,
  output logic            irq_o,
  output logic [TW-1:0]   timer_o,
  output logic [2:0]      mode_o,
  output logic            trig_stat_o,
  output logic            fault_o
);

  localparam logic [1:0] M_OFF = 2'd0, M_TGL = 2'd1, M_ONE = 2'd2, M_RPT = 2'd3;

  logic [1:0]    mode_q;
  logic [TW-1:0] timer_q;
  logic          raw_q, irq_q, trig_q, fault_q;
  logic          tick_hit, evt_hit;

  always_comb begin
    tick_hit = 1'b0;
    for (int i = 0; i < NTICK; i++)
      if (tick_sel_i == TSW'(i)) tick_hit = tick_i[i];
    evt_hit = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (evt_sel_i == SRCW'(i + 1)) evt_hit = evt_i[i];
  end

  wire          active   = (mode_q != M_OFF);
  wire          running  = active && (!trig_en_i || trig_q);
  wire          step     = running && tick_hit;
  wire          wrap     = (timer_q == period_i);
  wire [TW-1:0] t_next   = wrap ? '0 : timer_q + TW'(1);
  wire          sync_clr = active && !trig_en_i && evt_hit;
  wire          adv      = step && !sync_clr;
  wire          hit_a    = adv && (t_next == cmp_a_i);
  wire          hit_b    = adv && (t_next == cmp_b_i);

  always_ff @(posedge clk) begin
    if (!rst_n)        timer_q <= '0;
    else if (!active)  timer_q <= '0;
    else if (sync_clr) timer_q <= '0;
    else if (step)     timer_q <= t_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       mode_q <= M_OFF;
    else if (mode_wr_i && !mode_i[2]) mode_q <= mode_i[1:0];
    else if (mode_q == M_ONE && hit_b) mode_q <= M_OFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= 1'b0;
    else begin
      case (mode_q)
        M_OFF: raw_q <= 1'b0;
        M_TGL: if (hit_a) raw_q <= ~raw_q;
        default: begin
          if (hit_b)      raw_q <= 1'b0;
          else if (hit_a) raw_q <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= hit_a | ((mode_q != M_TGL) & hit_b);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                    trig_q <= 1'b0;
    else if ((trig_en_i && evt_hit) || sw_trig_set_i) trig_q <= 1'b1;
    else if (sw_trig_clr_i || (trig_auto_clr_i && step && wrap)) trig_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           fault_q <= 1'b0;
    else if (fault_i)     fault_q <= 1'b1;
    else if (fault_clr_i) fault_q <= 1'b0;
  end

  assign oc_o        = fault_q ? fault_level_i : (raw_q ^ invert_i);
  assign oc_oe_o     = !(fault_q && fault_tri_en_i);
  assign irq_o       = irq_q;
  assign timer_o     = timer_q;
  assign mode_o      = {1'b0, mode_q};
  assign trig_stat_o = trig_q;
  assign fault_o     = fault_q;

  p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap) |=> (timer_q == TW'($past(timer_q) + TW'(1))));
  p_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF) |=> !raw_q);
  p_single_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_ONE && hit_b && !mode_wr_i) |=> (mode_q == M_OFF && !raw_q));
  p_trig_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && trig_en_i && !trig_q) |=> $stable(timer_q));
  p_fault_cause_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(fault_i));
  p_fault_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !(fault_clr_i && !fault_i)) |=> fault_q);

endmodule

// File: tb/oc_pulse_gen_tb_top.sv
module oc_pulse_gen_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [3:0] tick_i;
  logic [1:0] tick_sel_i;
  logic [3:0] evt_i;
  logic [4:0] evt_sel_i;
  logic trig_en_i, trig_auto_clr_i, sw_trig_set_i, sw_trig_clr_i, mode_wr_i;
  logic [2:0] mode_i;
  logic [15:0] cmp_a_i, cmp_b_i, period_i;
  logic invert_i, fault_i, fault_level_i, fault_tri_en_i, fault_clr_i;
  logic oc_o, oc_oe_o, irq_o, trig_stat_o, fault_o;
  logic [15:0] timer_o;
  logic [2:0] mode_o;

  oc_pulse_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tick_sel_i(tick_sel_i),
    .evt_i(evt_i), .evt_sel_i(evt_sel_i), .trig_en_i(trig_en_i),
    .trig_auto_clr_i(trig_auto_clr_i), .sw_trig_set_i(sw_trig_set_i),
    .sw_trig_clr_i(sw_trig_clr_i), .mode_wr_i(mode_wr_i), .mode_i(mode_i),
    .cmp_a_i(cmp_a_i), .cmp_b_i(cmp_b_i), .period_i(period_i),
    .invert_i(invert_i), .fault_i(fault_i), .fault_level_i(fault_level_i),
    .fault_tri_en_i(fault_tri_en_i), .fault_clr_i(fault_clr_i),
    .oc_o(oc_o), .oc_oe_o(oc_oe_o), .irq_o(irq_o), .timer_o(timer_o),
    .mode_o(mode_o), .trig_stat_o(trig_stat_o), .fault_o(fault_o));

  localparam int K_OC = 0, K_OE = 1, K_IRQ = 2, K_TMR = 3, K_MODE = 4, K_TRIG = 5, K_FLT = 6;

  typedef struct {
    int    cyc;
    int    kind;
    int    val;
    string req;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int actual(int k);
    case (k)
      K_OC:   return int'(oc_o);
      K_OE:   return int'(oc_oe_o);
      K_IRQ:  return int'(irq_o);
      K_TMR:  return int'(timer_o);
      K_MODE: return int'(mode_o);
      K_TRIG: return int'(trig_stat_o);
      default: return int'(fault_o);
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        checks++;
        if (actual(sb[i].kind) != sb[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d kind %0d: actual %0d expected %0d",
                   sb[i].req, cyc, sb[i].kind, actual(sb[i].kind), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic exp(int d, int k, int v, string req);
    item_t it;
    it.cyc = cyc + d; it.kind = k; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_mode(logic [2:0] m);
    mode_i = m; mode_wr_i = 1'b1;
    step(1);
    mode_wr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      errors += sb.size();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    rst_n = 0; tick_i = 4'b0001; tick_sel_i = 0; evt_i = 0; evt_sel_i = 0;
    trig_en_i = 0; trig_auto_clr_i = 0; sw_trig_set_i = 0; sw_trig_clr_i = 0;
    mode_wr_i = 0; mode_i = 0; cmp_a_i = 0; cmp_b_i = 0; period_i = 16'hFFFF;
    invert_i = 0; fault_i = 0; fault_level_i = 0; fault_tri_en_i = 0; fault_clr_i = 0;
    step(3);
    // R1 reset state
    exp(0, K_OC, 0, "R1"); exp(0, K_OE, 1, "R1"); exp(0, K_IRQ, 0, "R1");
    exp(0, K_TMR, 0, "R1"); exp(0, K_MODE, 0, "R1"); exp(0, K_TRIG, 0, "R1");
    exp(0, K_FLT, 0, "R1");
    step(1);
    rst_n = 1;
    step(2);

    // R3 repeating pulse, R6 interrupt, R2 wrap
    cmp_a_i = 3; cmp_b_i = 6; period_i = 9;
    exp(4, K_OC, 1, "R3"); exp(4, K_IRQ, 1, "R6"); exp(5, K_IRQ, 0, "R6");
    exp(6, K_OC, 1, "R3"); exp(7, K_OC, 0, "R3"); exp(7, K_IRQ, 1, "R6");
    exp(10, K_TMR, 9, "R2"); exp(11, K_TMR, 0, "R2"); exp(14, K_OC, 1, "R3");
    exp(17, K_OC, 0, "R3");
    wr_mode(3'b011);
    step(18);
    // R2 tick gating
    tick_sel_i = 1;
    exp(1, K_TMR, 8, "R2"); exp(3, K_TMR, 8, "R2");
    step(3);
    tick_sel_i = 0;
    exp(1, K_TMR, 9, "R2"); exp(2, K_TMR, 0, "R2");
    step(3);
    exp(1, K_MODE, 0, "R7"); exp(2, K_TMR, 0, "R2"); exp(2, K_OC, 0, "R2");
    wr_mode(3'b000);
    step(3);

    // R12 inversion
    invert_i = 1; exp(0, K_OC, 1, "R12");
    step(1);
    invert_i = 0; exp(0, K_OC, 0, "R12");
    step(1);

    // R4 toggle
    cmp_a_i = 2; period_i = 4;
    exp(3, K_OC, 1, "R4"); exp(3, K_IRQ, 1, "R6"); exp(5, K_OC, 1, "R4");
    exp(8, K_OC, 0, "R4"); exp(13, K_OC, 1, "R4");
    wr_mode(3'b001);
    step(14);
    wr_mode(3'b000);
    step(2);

    // R7 write with top bit set is ignored
    exp(1, K_MODE, 0, "R7"); exp(3, K_TMR, 0, "R7");
    wr_mode(3'b110);
    step(3);

    // R5 single pulse
    cmp_a_i = 2; cmp_b_i = 4; period_i = 7;
    exp(3, K_OC, 1, "R5"); exp(4, K_MODE, 2, "R7"); exp(5, K_OC, 0, "R5");
    exp(5, K_IRQ, 1, "R6"); exp(5, K_MODE, 0, "R5"); exp(11, K_OC, 0, "R5");
    exp(11, K_TMR, 0, "R5");
    wr_mode(3'b010);
    step(12);

    // R8 sync reset
    evt_sel_i = 1; cmp_a_i = 2; cmp_b_i = 5; period_i = 20;
    exp(3, K_OC, 1, "R3"); exp(6, K_OC, 0, "R3"); exp(6, K_TMR, 5, "R8");
    exp(7, K_TMR, 0, "R8"); exp(9, K_OC, 1, "R8"); exp(9, K_TMR, 2, "R8");
    wr_mode(3'b011);
    step(5);
    evt_i[0] = 1;
    step(1);
    evt_i[0] = 0;
    step(4);
    evt_sel_i = 0; evt_i[0] = 1;
    exp(1, K_TMR, 5, "R8");
    step(1);
    evt_i[0] = 0;
    wr_mode(3'b000);
    step(2);

    // R9 software trigger, R11 auto clear
    trig_en_i = 1; trig_auto_clr_i = 1; cmp_a_i = 1; cmp_b_i = 3; period_i = 5;
    exp(5, K_TMR, 0, "R9"); exp(5, K_TRIG, 0, "R9");
    wr_mode(3'b011);
    step(5);
    sw_trig_set_i = 1;
    exp(1, K_TRIG, 1, "R9"); exp(2, K_TMR, 1, "R9"); exp(2, K_OC, 1, "R9");
    exp(4, K_OC, 0, "R9"); exp(6, K_TMR, 5, "R11"); exp(7, K_TMR, 0, "R11");
    exp(7, K_TRIG, 0, "R11"); exp(10, K_TMR, 0, "R11");
    step(1);
    sw_trig_set_i = 0;
    step(10);
    // R10 hardware trigger, R11 sticky status
    evt_sel_i = 2; trig_auto_clr_i = 0; evt_i[1] = 1;
    exp(1, K_TRIG, 1, "R10"); exp(2, K_TMR, 1, "R10"); exp(7, K_TMR, 0, "R11");
    exp(8, K_TRIG, 1, "R11"); exp(9, K_TMR, 2, "R11");
    step(1);
    evt_i[1] = 0;
    step(9);
    sw_trig_clr_i = 1;
    exp(1, K_TRIG, 0, "R11"); exp(1, K_TMR, 4, "R11"); exp(4, K_TMR, 4, "R11");
    step(1);
    sw_trig_clr_i = 0;
    step(4);
    trig_en_i = 0; evt_sel_i = 0;
    wr_mode(3'b000);
    step(2);

    // R13 fault override, R14 sticky flag
    cmp_a_i = 2; cmp_b_i = 5; period_i = 9; fault_level_i = 1;
    wr_mode(3'b011);
    step(1);
    fault_i = 1;
    exp(0, K_FLT, 0, "R14"); exp(1, K_FLT, 1, "R14"); exp(1, K_OC, 1, "R13");
    exp(1, K_OE, 1, "R13");
    step(1);
    fault_clr_i = 1;
    exp(1, K_FLT, 1, "R14");
    step(1);
    fault_clr_i = 0; fault_i = 0;
    exp(3, K_FLT, 1, "R14");
    step(3);
    fault_level_i = 0; invert_i = 1; fault_tri_en_i = 1;
    exp(0, K_OC, 0, "R13"); exp(0, K_OE, 0, "R13");
    step(1);
    fault_tri_en_i = 0; invert_i = 0; fault_clr_i = 1;
    exp(1, K_FLT, 0, "R14"); exp(1, K_OE, 1, "R13");
    step(1);
    fault_clr_i = 0;
    step(2);
    wr_mode(3'b000);
    step(3);
    finish_run();
  end
endmodule